// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Snapshot Registers

This block keeps wall-clock time in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and century. A one-cycle pulse on `tick_1hz` advances the running counters by one second. The counters handle month lengths, leap years, weekday wrap and the rollover from year 99 into the next century, so the range runs to 9999.

Software reaches the clock through a sixteen-byte window at the top of the bus address space. Offset 0 is a control byte with two bits. One bit freezes a readable snapshot. The other bit opens the holding registers so a new base time can be written. The readable bytes are holding registers, separate from the running counters. While neither bit is set they follow the counters. Setting either bit freezes them, and the counters keep running underneath without losing a second. Clearing the load bit copies the holding registers into the counters, and counting goes on from that base.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the control byte reads 0x00 and the time reads 20:00 century, year 00, month 01, date 01, weekday 01, 00:00:00.
- R2: The window responds only when every address bit above the low four is 1. Offset 0 is the control byte, with bit 0 = freeze and bit 1 = load and bits 7:2 reading 0. Offsets 9 to 15 and all addresses outside the window read 0x00.
- R3: Offsets 1 to 8 hold seconds, minutes, hours, weekday, date, month, year and century. Unused bits read 0, using the masks 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F, 0xFF and 0xFF.
- R4: Each tick advances the seconds by one. 59 seconds carries into minutes, 59 minutes carries into hours, and hour 23 rolls to 00. Without a tick the time does not change.
- R5: The hour rollover advances both the weekday (07 wraps to 01) and the date. The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months apart from February.
- R6: February ends at 29 when the year value is divisible by 4, and at 28 otherwise.
- R7: Year 99 rolls to 00 and increments the century. Century 99 with year 99 rolls to 0000.
- R8: While freeze is 1 the readable registers hold still and the counters keep counting. After freeze is cleared, all fields show the live count one clock later, with no seconds lost.
- R9: While load is 1, field writes land in the holding registers and ticks do not change them. Writing the control byte with load = 0 copies the holding registers into the counters, and counting resumes from that base.
- R10: Field writes are ignored while load is 0, whether or not freeze is set.
- R11: A nibble that is not valid BCD counts up in binary to 0xF and wraps to 0x0 without carrying into the next field. It then counts normally.
- R12: With freeze and load both set, load decides: field writes are accepted. Clearing only load transfers the base while the snapshot stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
The embedded properties check on every cycle that the counters stay still without a tick or load, that a load copies the holding registers exactly, that weekday and year carries wrap to the right values, and that frozen holding registers stay stable. The bench scenarios are the only place that shows calendar results across several fields: month lengths, the leap-year February, century turnover, masked field bits, invalid-nibble counting, and that no seconds are lost across a freeze. The bench also checks that the load bit takes priority over the freeze bit.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 8;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  // field indices; register offset is index + 1
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  // control byte bit positions
  localparam int FLAG_FREEZE = 0;
  localparam int FLAG_LOAD   = 1;

  typedef logic [NUM_FIELDS-1:0][7:0] cal_vec_t;

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_WDAY:         return 8'h07;
      F_MON:          return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_floor(input int idx);
    case (idx)
      F_WDAY, F_DATE, F_MON: return 8'h01;
      default:               return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int idx);
    case (idx)
      F_CENT:                return 8'h20;
      F_WDAY, F_DATE, F_MON: return 8'h01;
      default:               return 8'h00;
    endcase
  endfunction

  // fixed upper limit of a field (date is computed separately)
  function automatic logic [7:0] field_limit(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h59;
      F_HOUR:         return 8'h23;
      F_WDAY:         return 8'h07;
      F_MON:          return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'h0, yr[7:4]} * 8'd10) + {4'h0, yr[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // one BCD step; an invalid low nibble runs on to F and wraps without carry
  function automatic logic [7:0] nibble_step(input logic [7:0] v);
    logic [3:0] hi, lo;
    hi = v[7:4];
    lo = v[3:0];
    if (lo == 4'h9) return {hi + 4'h1, 4'h0};
    return {hi, lo + 4'h1};
  endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  load,
  input  cal_vec_t              base,
  output cal_vec_t              cnt,
  output logic [NUM_FIELDS-1:0] carry
);

  cal_vec_t              limit;
  cal_vec_t              nxt;
  logic [NUM_FIELDS-1:0] at_lim;
  logic [NUM_FIELDS-1:0] step_en;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (i == F_DATE) begin : g_dyn
      assign limit[i] = month_days(cnt[F_MON], cnt[F_YEAR]);
    end else begin : g_fix
      assign limit[i] = field_limit(i);
    end
    assign at_lim[i] = (cnt[i] == limit[i]);
    assign nxt[i]    = at_lim[i] ? field_floor(i) : (nibble_step(cnt[i]) & field_mask(i));
  end

  // ripple of enables along the carry chain; hour feeds weekday and date
  always_comb begin
    logic run;
    run             = tick;
    step_en[F_SEC]  = run;
    run             = run & at_lim[F_SEC];
    step_en[F_MIN]  = run;
    run             = run & at_lim[F_MIN];
    step_en[F_HOUR] = run;
    run             = run & at_lim[F_HOUR];
    step_en[F_WDAY] = run;
    step_en[F_DATE] = run;
    run             = run & at_lim[F_DATE];
    step_en[F_MON]  = run;
    run             = run & at_lim[F_MON];
    step_en[F_YEAR] = run;
    run             = run & at_lim[F_YEAR];
    step_en[F_CENT] = run;
  end

  assign carry = step_en & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIELDS; i++) cnt[i] <= field_reset(i);
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (load)            cnt[i] <= base[i];
        else if (step_en[i]) cnt[i] <= nxt[i];
      end
    end
  end

  // R4: no tick and no load leaves every counter unchanged
  a_r4_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  // R9: a transfer copies the holding registers exactly
  a_r9_base_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(base)));

  // R5: weekday wraps to 1
  a_r5_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[F_WDAY] && !load) |=> (cnt[F_WDAY] == 8'h01));

  // R7: year rollover clears year and moves the century
  a_r7_century_step: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[F_YEAR] && !load) |=> (cnt[F_YEAR] == 8'h00 && cnt[F_CENT] != $past(cnt[F_CENT])));

endmodule

// File: rtl/rtc_reg_window.sv
module rtc_reg_window
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  cal_vec_t          cnt,
  output logic [7:0]        rd_data,
  output cal_vec_t          hold,
  output logic              load_go
);

  localparam int         OFF_W    = 4;
  localparam logic [3:0] LAST_OFF = 4'(NUM_FIELDS);

  logic             freeze_q, load_q;
  logic             win_hit, flag_sel, fld_sel, flag_wr, fld_wr, mirror;
  logic [OFF_W-1:0] off, fld_idx;

  assign win_hit  = &addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign flag_sel = win_hit && (off == 4'h0);
  assign fld_sel  = win_hit && (off >= 4'h1) && (off <= LAST_OFF);
  assign fld_idx  = off - 4'h1;
  assign flag_wr  = wr_en && flag_sel;
  assign fld_wr   = wr_en && fld_sel && load_q;
  assign load_go  = flag_wr && load_q && !wr_data[FLAG_LOAD];
  assign mirror   = !freeze_q && !load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      load_q   <= 1'b0;
    end else if (flag_wr) begin
      freeze_q <= wr_data[FLAG_FREEZE];
      load_q   <= wr_data[FLAG_LOAD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIELDS; i++) hold[i] <= field_reset(i);
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (fld_wr && (fld_idx == 4'(i))) hold[i] <= wr_data & field_mask(i);
        else if (mirror)                  hold[i] <= cnt[i] & field_mask(i);
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (flag_sel) begin
      rd_data[FLAG_FREEZE] = freeze_q;
      rd_data[FLAG_LOAD]   = load_q;
    end else if (fld_sel) begin
      rd_data = hold[fld_idx[IDX_W-1:0]];
    end
  end

  // R8: a frozen snapshot moves only through accepted field writes
  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mirror && !fld_wr) |=> $stable(hold));

  // R10: a field write with load clear while frozen changes nothing
  a_r10_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fld_sel && !load_q && freeze_q) |=> $stable(hold));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  cal_vec_t              hold_vec;
  cal_vec_t              live_vec;
  logic                  load_go;
  logic [NUM_FIELDS-1:0] field_carry;

  rtc_reg_window #(.ADDR_W(ADDR_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .wr_data (bus_wdata),
    .cnt     (live_vec),
    .rd_data (bus_rdata),
    .hold    (hold_vec),
    .load_go (load_go)
  );

  rtc_time_counter u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1hz),
    .load  (load_go),
    .base  (hold_vec),
    .cnt   (live_vec),
    .carry (field_carry)
  );

endmodule

// File: tb/rtc_bcd_calendar_tb_top.sv
module rtc_bcd_calendar_tb_top;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  always #4 clk = ~clk;

  rtc_bcd_calendar #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    exp;
    string         req;
  } chk_t;

  chk_t sb_q[$];
  int   n_checks = 0;
  int   n_err = 0;
  bit   done = 0;

  // monitor: pops one expectation per cycle and compares away from the edge
  always @(negedge clk) begin
    chk_t c;
    if (sb_q.size() > 0) begin
      c = sb_q.pop_front();
      n_checks++;
      if (rdata !== c.exp) begin
        n_err++;
        $display("FAIL %s addr=%h actual=%h expected=%h", c.req, c.a, rdata, c.exp);
      end
    end
  end

  function automatic logic [AW-1:0] win(input logic [3:0] off);
    return {{(AW-4){1'b1}}, off};
  endfunction

  task automatic wr_reg(input logic [3:0] off, input logic [7:0] d);
    @(posedge clk); #1;
    addr = win(off); wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    chk_t c;
    @(posedge clk); #1;
    addr = a;
    c.a = a; c.exp = exp; c.req = req;
    sb_q.push_back(c);
    @(negedge clk); #1;
  endtask

  task automatic rd_reg(input logic [3:0] off, input logic [7:0] exp, input string req);
    rd_raw(win(off), exp, req);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, wd, dt, mo, y, ce);
    wr_reg(0, 8'h02);
    wr_reg(1, s);  wr_reg(2, mi); wr_reg(3, h);  wr_reg(4, wd);
    wr_reg(5, dt); wr_reg(6, mo); wr_reg(7, y);  wr_reg(8, ce);
    wr_reg(0, 8'h00);
  endtask

  task automatic rd_date(input logic [7:0] wd, dt, mo, y, ce, input string req);
    rd_reg(4, wd, req); rd_reg(5, dt, req); rd_reg(6, mo, req);
    rd_reg(7, y, req);  rd_reg(8, ce, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(0, 8'h00, "R1");
    rd_reg(1, 8'h00, "R1"); rd_reg(2, 8'h00, "R1"); rd_reg(3, 8'h00, "R1");
    rd_date(8'h01, 8'h01, 8'h01, 8'h00, 8'h20, "R1");

    // R2 decode outside the fields
    rd_reg(9, 8'h00, "R2");
    rd_reg(15, 8'h00, "R2");
    rd_raw(8'h31, 8'h00, "R2");

    // R4 single step, R10 ignored write, idle cycles
    ticks(1);
    rd_reg(1, 8'h01, "R4");
    wr_reg(1, 8'h45);
    repeat (5) @(posedge clk);
    rd_reg(1, 8'h01, "R10");

    // R9 / R3 base load into holding registers
    wr_reg(0, 8'h02);
    rd_reg(0, 8'h02, "R2");
    wr_reg(1, 8'hFF); rd_reg(1, 8'h7F, "R3");
    wr_reg(3, 8'hFF); rd_reg(3, 8'h3F, "R3");
    wr_reg(4, 8'hFF); rd_reg(4, 8'h07, "R3");
    wr_reg(6, 8'hFF); rd_reg(6, 8'h1F, "R3");
    wr_reg(1, 8'h58); wr_reg(2, 8'h59); wr_reg(3, 8'h23); wr_reg(4, 8'h07);
    wr_reg(5, 8'h31); wr_reg(6, 8'h12); wr_reg(7, 8'h99); wr_reg(8, 8'h99);
    ticks(3);
    rd_reg(1, 8'h58, "R9");
    wr_reg(0, 8'h00);
    rd_reg(1, 8'h58, "R9");
    ticks(1);
    rd_reg(1, 8'h59, "R9");
    ticks(1);
    // R4 R5 R7 full rollover 9999-12-31 23:59:59 -> 0000-01-01
    rd_reg(1, 8'h00, "R4"); rd_reg(2, 8'h00, "R4"); rd_reg(3, 8'h00, "R4");
    rd_date(8'h01, 8'h01, 8'h01, 8'h00, 8'h00, "R7");

    // R7 century increment
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h19);
    ticks(1);
    rd_date(8'h06, 8'h01, 8'h01, 8'h00, 8'h20, "R7");

    // R6 leap and common February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    ticks(1);
    rd_reg(5, 8'h29, "R6"); rd_reg(6, 8'h02, "R6"); rd_reg(4, 8'h04, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24, 8'h20);
    ticks(1);
    rd_reg(5, 8'h01, "R6"); rd_reg(6, 8'h03, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    ticks(1);
    rd_reg(5, 8'h01, "R6"); rd_reg(6, 8'h03, "R6");

    // R5 thirty- and thirty-one-day months
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23, 8'h20);
    ticks(1);
    rd_reg(5, 8'h01, "R5"); rd_reg(6, 8'h05, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h23, 8'h20);
    ticks(1);
    rd_reg(5, 8'h31, "R5"); rd_reg(6, 8'h05, "R5");

    // R11 invalid low nibble runs to F and wraps without carry
    set_time(8'h0C, 8'h10, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    ticks(2);
    rd_reg(1, 8'h0E, "R11");
    ticks(2);
    rd_reg(1, 8'h00, "R11"); rd_reg(2, 8'h10, "R11");
    ticks(1);
    rd_reg(1, 8'h01, "R11");

    // R8 freeze with counting underneath, R10 write ignored while frozen
    set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    wr_reg(0, 8'h01);
    ticks(5);
    rd_reg(1, 8'h00, "R8");
    rd_reg(0, 8'h01, "R8");
    wr_reg(1, 8'h33);
    rd_reg(1, 8'h00, "R10");
    wr_reg(0, 8'h00);
    rd_reg(1, 8'h05, "R8"); rd_reg(2, 8'h00, "R8"); rd_reg(3, 8'h10, "R8");

    // R12 load wins over freeze
    wr_reg(0, 8'h03);
    wr_reg(1, 8'h40);
    rd_reg(1, 8'h40, "R12");
    rd_reg(0, 8'h03, "R12");
    wr_reg(0, 8'h01);
    ticks(2);
    rd_reg(1, 8'h40, "R12");
    wr_reg(0, 8'h00);
    rd_reg(1, 8'h42, "R12");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule